// File: doc/BRIEF.md
# Descriptor-Driven Memory-to-Memory DMA Engine

This block is a single-channel copy engine. Software fills a small set of descriptor registers through a write-only load port, then pulses a start strobe. The engine moves data from a source region to a destination region over a 64-bit memory bus with a valid/ready handshake. It works through two nested loops: the inner loop covers a byte count, and the outer loop repeats it a set number of times. It raises a one-cycle done pulse when the outer loop runs out.

Each element is read completely and then written completely, and only one bus access is pending at any time. After an element, each side's address moves by its own signed step. When the final outer iteration ends, both addresses also take a signed closing correction. The descriptor's address registers are updated in place, so the final adjusted addresses remain visible on the address outputs afterwards. A throttle field can insert idle cycles between elements.

Descriptor register indices on `cfg_addr`:

| Index | Content |
|-------|---------|
| 0 | source address |
| 1 | destination address |
| 2 | source step, signed, bits [15:0] |
| 3 | destination step, signed, bits [15:0] |
| 4 | attributes: destination size code [2:0], source size code [6:4], throttle [9:8] |
| 5 | inner-loop byte count |
| 6 | outer-loop iteration count [15:0] |
| 7 | source closing correction, signed 32-bit |
| 8 | destination closing correction, signed 32-bit |

Top module: `dma_tcd_engine`

## Requirements
- R1: Out of reset, busy, done, err and m_req are all 0.
- R2: The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes and 5 = 32 bytes. Source and destination codes must be equal. Codes 4, 6 and 7 are reserved and are rejected at start. m_size reports the beat width code, which is the size code capped at 3.
- R3: Each element is all of its read beats (m_we = 0) followed by all of its write beats (m_we = 1). A request holds m_req, m_we and m_addr stable until m_ready is seen. m_req is 0 whenever busy is 0.
- R4: After an element's reads, the source address advances by the sign-extended source step. After its writes, the destination address advances by the sign-extended destination step. A 32-byte element uses four beats at base, base+8, base+16 and base+24 on each side.
- R5: One inner loop is (byte count / element size) elements. The inner loop is repeated for the outer-loop count, and the transfer then ends.
- R6: When the last outer iteration ends, the signed source and destination closing corrections are added to the respective addresses. The results are shown on src_addr and dst_addr.
- R7: The throttle field inserts idle cycles (busy = 1, m_req = 0) after each element except the last. Value 2 gives 4 idle cycles, value 3 gives 8, and values 0 and 1 give none.
- R8: Start is rejected with err = 1, busy staying 0 and no bus traffic in any of these cases: a zero byte count, a byte count that is not a multiple of the element size, a zero outer count, or a bad size code (R2). A later valid start clears err.
- R9: busy is 1 from the cycle after an accepted start until done. done is a one-cycle pulse coincident with busy falling. Descriptor writes made while busy are ignored.
- R10: The data written on each write beat equals the data returned by the read beat with the same beat index in the same element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | descriptor register write enable |
| cfg_addr | input | 4 | descriptor register index |
| cfg_wdata | input | 32 | descriptor register write data |
| start | input | 1 | launch strobe |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle end-of-transfer pulse |
| err | output | 1 | last start was rejected |
| src_addr | output | 32 | current source address |
| dst_addr | output | 32 | current destination address |
| m_req | output | 1 | bus request valid |
| m_we | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | 32 | beat address |
| m_size | output | 3 | beat width code |
| m_wdata | output | 64 | write data |
| m_rdata | input | 64 | read data, valid with m_ready on a read |
| m_ready | input | 1 | beat accepted / completed |

## Verification
The scoreboard predicts every bus beat, including address, direction and write data, and compares the beats in order. As a result, a wrong step sign, a missed closing correction, a swapped beat order inside a 32-byte element, or a stale write buffer each shows up as a mismatched beat.

Idle cycles are counted per transfer. An engine that stalls after the final element, or that decodes the throttle field wrongly, gives the wrong count.

The bench also covers the following cases:
- A descriptor written mid-flight must not change the transfer. An engine that accepts the write would fetch from the poked address.
- Malformed descriptors must raise err with zero bus beats.
- Random ready stalls check that a request is held rather than dropped or repeated.

// File: rtl/dma_tcd_engine.sv
module dma_tcd_engine #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int MAJW = 16,
  parameter int STW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [2:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int MAX_BEATS  = 4;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_STALL} st_t;
  st_t state;

  logic [AW-1:0]   src_q, dst_q, nbytes_q, slast_q, dlast_q, elem_left;
  logic [15:0]     soff_q, doff_q;
  logic [2:0]      ssz_q, dsz_q;
  logic [1:0]      bwc_q, beat;
  logic [MAJW-1:0] major_q, maj_left;
  logic [STW-1:0]  stall_cnt;
  logic [DW-1:0]   buf_q [MAX_BEATS];

  wire size_ok = (ssz_q == dsz_q) && (ssz_q <= 3'd3 || ssz_q == 3'd5);
  wire [2:0] shift = ssz_q;
  wire [AW-1:0] elem_bytes = AW'(1) << shift;
  wire [1:0] last_beat = (ssz_q == 3'd5) ? 2'd3 : 2'd0;
  wire desc_ok = size_ok && nbytes_q != '0 && (nbytes_q & (elem_bytes - AW'(1))) == '0
                 && major_q != '0;
  wire [STW-1:0] stall_len = (bwc_q == 2'd3) ? STW'(8) : (bwc_q == 2'd2) ? STW'(4) : '0;

  wire rd_end = state == S_RD && m_ready && beat == last_beat;
  wire wr_end = state == S_WR && m_ready && beat == last_beat;
  wire elem_last = elem_left == AW'(1);
  wire fin = wr_end && elem_last && maj_left == MAJW'(1);

  assign busy     = state != S_IDLE;
  assign m_req    = state == S_RD || state == S_WR;
  assign m_we     = state == S_WR;
  assign m_addr   = (m_we ? dst_q : src_q) + AW'(beat) * AW'(BEAT_BYTES);
  assign m_size   = (ssz_q > 3'd3) ? 3'd3 : ssz_q;
  assign m_wdata  = buf_q[beat];
  assign src_addr = src_q;
  assign dst_addr = dst_q;

  always_ff @(posedge clk) begin
    if (state == S_RD && m_ready) buf_q[beat] <= m_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; done <= 1'b0; err <= 1'b0; beat <= '0; stall_cnt <= '0;
      src_q <= '0; dst_q <= '0; nbytes_q <= '0; slast_q <= '0; dlast_q <= '0;
      soff_q <= '0; doff_q <= '0; ssz_q <= '0; dsz_q <= '0; bwc_q <= '0;
      major_q <= '0; maj_left <= '0; elem_left <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cfg_we) begin
            case (cfg_addr)
              4'd0: src_q    <= cfg_wdata;
              4'd1: dst_q    <= cfg_wdata;
              4'd2: soff_q   <= cfg_wdata[15:0];
              4'd3: doff_q   <= cfg_wdata[15:0];
              4'd4: begin dsz_q <= cfg_wdata[2:0]; ssz_q <= cfg_wdata[6:4]; bwc_q <= cfg_wdata[9:8]; end
              4'd5: nbytes_q <= cfg_wdata;
              4'd6: major_q  <= cfg_wdata[MAJW-1:0];
              4'd7: slast_q  <= cfg_wdata;
              4'd8: dlast_q  <= cfg_wdata;
              default: ;
            endcase
          end
          if (start) begin
            err <= !desc_ok;
            if (desc_ok) begin
              state     <= S_RD;
              beat      <= '0;
              elem_left <= nbytes_q >> shift;
              maj_left  <= major_q;
            end
          end
        end
        S_RD: if (m_ready) begin
          beat <= rd_end ? 2'd0 : beat + 2'd1;
          if (rd_end) begin
            src_q <= src_q + AW'(signed'(soff_q));
            state <= S_WR;
          end
        end
        S_WR: if (m_ready) begin
          beat <= wr_end ? 2'd0 : beat + 2'd1;
          if (wr_end) begin
            dst_q <= dst_q + AW'(signed'(doff_q)) + (fin ? dlast_q : '0);
            if (fin) begin
              src_q <= src_q + slast_q;
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              if (elem_last) begin
                elem_left <= nbytes_q >> shift;
                maj_left  <= maj_left - MAJW'(1);
              end else begin
                elem_left <= elem_left - AW'(1);
              end
              stall_cnt <= stall_len;
              state     <= (stall_len != '0) ? S_STALL : S_RD;
            end
          end
        end
        S_STALL: begin
          stall_cnt <= stall_cnt - STW'(1);
          if (stall_cnt == STW'(1)) state <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_tcd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [2:0]    m_size,
  input logic          m_ready
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_we)); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_req); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R8
  AST_BEAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> m_size <= 3'd3); // R2
endmodule

bind dma_tcd_engine dma_tcd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_ready(m_ready)
);

// File: tb/dma_tcd_engine_tb.sv
module dma_tcd_engine_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, start = 0, m_ready = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic busy, done, err, m_req, m_we;
  logic [31:0] src_addr, dst_addr, m_addr;
  logic [2:0] m_size;
  logic [63:0] m_wdata, m_rdata;

  always #2.5 clk = ~clk;

  assign m_rdata = {m_addr, ~m_addr};

  dma_tcd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .busy(busy), .done(done), .err(err), .src_addr(src_addr), .dst_addr(dst_addr),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready)
  );

  typedef struct packed { logic we; logic [31:0] addr; logic [63:0] data; } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0, idle_cnt = 0, txn_cnt = 0;
  bit rdy_rand = 0;
  logic [7:0] lf = 8'h5a;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    exp_t e;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    rdy = rdy_rand ? (lf[0] | lf[1]) : 1'b1;
    if (busy && !m_req) idle_cnt++;
    if (m_req && rdy) begin
      txn_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected beat addr", 64'(m_addr), 64'(0));
      end else begin
        e = exp_q.pop_front();
        check(m_we == e.we, "R3", "beat direction", 64'(m_we), 64'(e.we));
        check(m_addr == e.addr, "R4", "beat address", 64'(m_addr), 64'(e.addr));
        if (e.we) check(m_wdata == e.data, "R10", "write data", m_wdata, e.data);
      end
    end
    m_ready = rdy;
  end

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_desc(input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] so, input logic [15:0] dof,
                          input logic [2:0] ss, input logic [2:0] ds, input logic [1:0] bw,
                          input logic [31:0] nb, input logic [15:0] mj,
                          input logic [31:0] sl, input logic [31:0] dl,
                          input bit rnd, input bit poke, input bit exp_err, input string tag);
    logic [31:0] cs, cd;
    int elems, beats, bytes, stall, total;
    cfg_write(0, s); cfg_write(1, d); cfg_write(2, 32'(so)); cfg_write(3, 32'(dof));
    cfg_write(4, 32'(ds) | (32'(ss) << 4) | (32'(bw) << 8));
    cfg_write(5, nb); cfg_write(6, 32'(mj)); cfg_write(7, sl); cfg_write(8, dl);
    rdy_rand = rnd;
    cs = s; cd = d; total = 0;
    bytes = (ss == 3'd5) ? 32 : (1 << ss);
    beats = (ss == 3'd5) ? 4 : 1;
    stall = (bw == 2'd3) ? 8 : (bw == 2'd2) ? 4 : 0;
    if (!exp_err) begin
      elems = int'(nb) / bytes;
      for (int m = 0; m < int'(mj); m++)
        for (int e = 0; e < elems; e++) begin
          for (int b = 0; b < beats; b++)
            exp_q.push_back('{1'b0, cs + 32'(8 * b), 64'(0)});
          for (int b = 0; b < beats; b++) begin
            logic [31:0] ra;
            ra = cs + 32'(8 * b);
            exp_q.push_back('{1'b1, cd + 32'(8 * b), {ra, ~ra}});
          end
          cs = cs + {{16{so[15]}}, so};
          cd = cd + {{16{dof[15]}}, dof};
          total++;
        end
      cs = cs + sl; cd = cd + dl;
    end
    txn_cnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    idle_cnt = 0;
    if (exp_err) begin
      repeat (5) @(negedge clk);
      check(err == 1'b1, "R8", {tag, " err flag"}, 64'(err), 64'(1));
      check(busy == 1'b0, "R8", {tag, " busy stays low"}, 64'(busy), 64'(0));
      check(txn_cnt == 0, "R8", {tag, " no bus beats"}, 64'(txn_cnt), 64'(0));
    end else begin
      check(busy == 1'b1, "R9", {tag, " busy after start"}, 64'(busy), 64'(1));
      if (poke) begin
        repeat (3) @(negedge clk);
        cfg_write(0, 32'hDEAD_0000); cfg_write(4, 32'h0); cfg_write(6, 32'h7);
      end
      while (!done) @(negedge clk);
      check(err == 1'b0, "R8", {tag, " err clear"}, 64'(err), 64'(0));
      check(busy == 1'b0, "R9", {tag, " busy falls with done"}, 64'(busy), 64'(0));
      check(src_addr == cs, "R6", {tag, " final source"}, 64'(src_addr), 64'(cs));
      check(dst_addr == cd, "R6", {tag, " final destination"}, 64'(dst_addr), 64'(cd));
      check(exp_q.size() == 0, "R5", {tag, " all beats seen"}, 64'(exp_q.size()), 64'(0));
      check(idle_cnt == (total - 1) * stall, "R7", {tag, " throttle idle cycles"},
            64'(idle_cnt), 64'((total - 1) * stall));
      @(negedge clk);
      check(done == 1'b0, "R9", {tag, " done is one cycle"}, 64'(done), 64'(0));
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0 && err == 0 && m_req == 0, "R1", "reset outputs",
          {60'(0), busy, done, err, m_req}, 64'(0));
    rst_n = 1;
    @(negedge clk);
    run_desc(32'h1000, 32'h2000, 16'd8, 16'd8, 3'd3, 3'd3, 2'd0, 32'd32, 16'd2,
             32'hFFFF_FFC0, 32'hFFFF_FFC0, 0, 0, 0, "R4 R5 64-bit two passes");
    run_desc(32'h4000, 32'h8000, 16'd32, 16'd32, 3'd5, 3'd5, 2'd3, 32'd64, 16'd2,
             32'd0, 32'h10, 0, 0, 0, "R2 R7 burst bwc3");
    run_desc(32'h300, 32'h5FF, 16'd1, 16'hFFFF, 3'd0, 3'd0, 2'd2, 32'd4, 16'd1,
             32'd100, 32'hFFFF_FF00, 0, 0, 0, "R4 R7 byte negative step bwc2");
    run_desc(32'hA000, 32'hB000, 16'd2, 16'd4, 3'd1, 3'd1, 2'd1, 32'd6, 16'd3,
             32'd0, 32'd0, 1, 0, 0, "R3 R7 halfword random ready bwc1");
    run_desc(32'hC000, 32'hD000, 16'd4, 16'd4, 3'd2, 3'd2, 2'd2, 32'd16, 16'd2,
             32'hFFFF_FFE0, 32'd8, 1, 1, 0, "R9 writes while busy ignored");
    run_desc(32'h0, 32'h100, 16'd4, 16'd4, 3'd2, 3'd2, 2'd0, 32'd6, 16'd1,
             32'd0, 32'd0, 0, 0, 1, "R8 unaligned count");
    run_desc(32'h0, 32'h100, 16'd8, 16'd8, 3'd3, 3'd3, 2'd0, 32'd8, 16'd0,
             32'd0, 32'd0, 0, 0, 1, "R8 zero major");
    run_desc(32'h0, 32'h100, 16'd8, 16'd8, 3'd3, 3'd3, 2'd0, 32'd0, 16'd1,
             32'd0, 32'd0, 0, 0, 1, "R8 zero bytes");
    run_desc(32'h0, 32'h100, 16'd8, 16'd8, 3'd4, 3'd4, 2'd0, 32'd32, 16'd1,
             32'd0, 32'd0, 0, 0, 1, "R2 reserved size");
    run_desc(32'h0, 32'h100, 16'd8, 16'd8, 3'd3, 3'd2, 2'd0, 32'd32, 16'd1,
             32'd0, 32'd0, 0, 0, 1, "R2 mismatched sizes");
    run_desc(32'h2220, 32'h3330, 16'd8, 16'd8, 3'd3, 3'd3, 2'd0, 32'd8, 16'd1,
             32'd0, 32'd0, 1, 0, 0, "R8 valid start clears err");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule